// File: doc/BRIEF.md
# Duty-Cycled Hysteretic Field Latch

This block is the digital decision stage of a duty-cycled magnetic switch. A power sequencer opens an awake window by raising `awake_i`. While the window is open, each clock cycle presents a signed field sample on `field_i`. Every sample is sorted into one of three classes: at or above the operate threshold, at or below the release threshold, or inside the band between them. Only the class of the final sample in the window counts. That class is applied when the window closes.

The output `out_high_o` is active low. It goes low (on) after an operate-class capture and high (off) after a release-class capture. An in-band capture leaves it unchanged. Between windows the sensor sleeps, and the output holds its last value whatever the field does. A one-cycle `toggle_o` pulse marks every capture that changes the output, so downstream timers can move between slow and fast sampling. `valid_o` stays low after reset until the first capture that crosses either threshold. This shows when the output level is real and not the reset default.

Thresholds are parameters. They are signed values in units of 0.1 gauss, with defaults of +360 and −360, and the operate threshold must be greater than the release threshold.

Top module: `hyst_field_latch`

## Requirements
- R1: On reset, `out_high_o` is 1, `valid_o` is 0 and `toggle_o` is 0.
- R2: When the last sample of a window is at or above `OPERATE_TH`, `out_high_o` is 0 from the clock edge where `awake_i` is first seen low.
- R3: When the last sample of a window is at or below `RELEASE_TH`, `out_high_o` is 1 from the clock edge where `awake_i` is first seen low.
- R4: When the last sample of a window lies strictly between the thresholds, `out_high_o` keeps its previous value.
- R5: `out_high_o` changes only at the clock edge that closes a window. It does not change while the window is open, and it does not change during sleep, whatever `field_i` carries.
- R6: Only the sample on the last awake cycle decides the capture. Earlier samples in the same window have no effect.
- R7: `toggle_o` is 1 for exactly the one cycle after a capture that changed `out_high_o`, and 0 at all other times.
- R8: `valid_o` stays 0 until the first capture of an operate-class or release-class sample, and then stays 1 until reset. While `valid_o` is 0, `out_high_o` is 1.
- R9: Threshold comparisons include equality. A sample equal to `OPERATE_TH` or `RELEASE_TH` counts as a crossing. `OPERATE_TH-1` and `RELEASE_TH+1` lie inside the band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awake_i | input | 1 | Awake window from the power sequencer; samples are taken while high |
| field_i | input | FIELD_W | Signed field sample in 0.1 gauss units |
| out_high_o | output | 1 | Latched switch output; 0 = on (operate), 1 = off (release) |
| toggle_o | output | 1 | One-cycle pulse after a capture that changed the output |
| valid_o | output | 1 | Set once the output has been decided by a real threshold crossing |

## Verification
The hardest situation to reach is a window whose early samples disagree with its last one. For example, a strong operate sample is followed by an in-band or release sample, and only the last one may count. The random windows are one to five cycles long, with independent random fields on every cycle, and directed windows cover this ordering explicitly. Field values are drawn with a bias toward each threshold ±2, so equality and off-by-one cases happen often. Sleep stretches also carry random fields, to show that nothing leaks into the output between windows.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic [1:0] {
    CMP_HOLD    = 2'd0,
    CMP_OPERATE = 2'd1,
    CMP_RELEASE = 2'd2
  } cmp_e;

  // Sort one sample against the two thresholds (inclusive on both sides).
  function automatic cmp_e fl_classify(input int sample, input int op_th, input int rp_th);
    cmp_e c;
    if (sample >= op_th)      c = CMP_OPERATE;
    else if (sample <= rp_th) c = CMP_RELEASE;
    else                      c = CMP_HOLD;
    return c;
  endfunction

  // Output level after a capture of class c; cur is the present level.
  function automatic logic fl_next_level(input cmp_e c, input logic cur);
    logic lvl;
    case (c)
      CMP_OPERATE: lvl = 1'b0;
      CMP_RELEASE: lvl = 1'b1;
      default:     lvl = cur;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/fl_threshold_cmp.sv
module fl_threshold_cmp
  import fl_pkg::*;
#(
  parameter int FIELD_W    = 12,
  parameter int OPERATE_TH = 360,
  parameter int RELEASE_TH = -360
) (
  input  logic signed [FIELD_W-1:0] field_i,
  output cmp_e                      cls_o
);

  if (OPERATE_TH <= RELEASE_TH) begin : g_bad_th
    $error("operate threshold must exceed release threshold");
  end

  int sample_int;

  always_comb begin
    sample_int = int'(field_i);
    cls_o      = fl_classify(sample_int, OPERATE_TH, RELEASE_TH);
  end

endmodule

// File: rtl/fl_window_track.sv
module fl_window_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic awake_i,
  output logic win_fall_o
);

  logic awake_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) awake_q <= 1'b0;
    else         awake_q <= awake_i;
  end

  assign win_fall_o = awake_q & ~awake_i;

endmodule

// File: rtl/fl_capture_core.sv
module fl_capture_core
  import fl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_en_i,
  input  logic win_fall_i,
  input  cmp_e cls_i,
  output cmp_e pend_o,
  output logic out_high_o,
  output logic valid_o,
  output logic toggle_o
);

  cmp_e pend_q;
  logic out_q, valid_q, tog_q, out_nxt;

  always_comb begin
    out_nxt = out_q;
    if (win_fall_i) out_nxt = fl_next_level(pend_q, out_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= CMP_HOLD;
      out_q   <= 1'b1;
      valid_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      if (sample_en_i) pend_q <= cls_i;
      out_q <= out_nxt;
      tog_q <= out_nxt ^ out_q;
      if (win_fall_i && (pend_q != CMP_HOLD)) valid_q <= 1'b1;
    end
  end

  assign pend_o     = pend_q;
  assign out_high_o = out_q;
  assign valid_o    = valid_q;
  assign toggle_o   = tog_q;

endmodule

// File: rtl/hyst_field_latch.sv
module hyst_field_latch
  import fl_pkg::*;
#(
  parameter int FIELD_W    = 12,
  parameter int OPERATE_TH = 360,
  parameter int RELEASE_TH = -360
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      awake_i,
  input  logic signed [FIELD_W-1:0] field_i,
  output logic                      out_high_o,
  output logic                      toggle_o,
  output logic                      valid_o
);

  cmp_e cur_cls;
  cmp_e pend_cls;
  logic win_fall;

  fl_threshold_cmp #(
    .FIELD_W   (FIELD_W),
    .OPERATE_TH(OPERATE_TH),
    .RELEASE_TH(RELEASE_TH)
  ) u_cmp (
    .field_i(field_i),
    .cls_o  (cur_cls)
  );

  fl_window_track u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .awake_i   (awake_i),
    .win_fall_o(win_fall)
  );

  fl_capture_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_en_i(awake_i),
    .win_fall_i (win_fall),
    .cls_i      (cur_cls),
    .pend_o     (pend_cls),
    .out_high_o (out_high_o),
    .valid_o    (valid_o),
    .toggle_o   (toggle_o)
  );

endmodule

// File: rtl/fl_latch_chk.sv
module fl_latch_chk
  import fl_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic win_fall,
  input cmp_e pend_cls,
  input logic out_high_o,
  input logic toggle_o,
  input logic valid_o
);

  assert_operate_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_fall && pend_cls == CMP_OPERATE) |=> (!out_high_o && valid_o));

  assert_release_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_fall && pend_cls == CMP_RELEASE) |=> (out_high_o && valid_o));

  assert_band_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_fall && pend_cls == CMP_HOLD) |=> $stable(out_high_o));

  assert_only_on_close_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_fall |=> $stable(out_high_o));

  assert_toggle_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_o |-> (out_high_o != $past(out_high_o)));

  assert_toggle_needed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(out_high_o) |-> toggle_o);

  assert_valid_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  assert_invalid_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> out_high_o);

endmodule

bind hyst_field_latch fl_latch_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .win_fall  (win_fall),
  .pend_cls  (pend_cls),
  .out_high_o(out_high_o),
  .toggle_o  (toggle_o),
  .valid_o   (valid_o)
);

// File: tb/tb_hyst_field_latch.sv
`timescale 1ns/1ps
module tb_hyst_field_latch;

  localparam int FW  = 12;
  localparam int OPT = 360;
  localparam int RPT = -360;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awake = 1'b0;
  logic signed [FW-1:0] field = '0;
  logic out_high, toggle, valid;

  int checks = 0;
  int errors = 0;
  logic exp_out = 1'b1;
  logic exp_valid = 1'b0;
  logic exp_tog = 1'b0;

  always #4 clk = ~clk;

  hyst_field_latch #(.FIELD_W(FW), .OPERATE_TH(OPT), .RELEASE_TH(RPT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .awake_i(awake), .field_i(field),
    .out_high_o(out_high), .toggle_o(toggle), .valid_o(valid)
  );

  // Bench's own model: 0 = hold, 1 = drive low, 2 = drive high
  function automatic int decide(input int f);
    if (f < OPT && f > RPT) return 0;
    return (f >= OPT) ? 1 : 2;
  endfunction

  function automatic int pick_field();
    int sel = int'($urandom_range(0, 3));
    if (sel == 0) return OPT + int'($urandom_range(0, 4)) - 2;
    if (sel == 1) return RPT + int'($urandom_range(0, 4)) - 2;
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  task automatic chk(input string req, input logic act, input logic expv, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, expv);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, out_high, exp_out, "out_high");
    chk("R7", toggle, exp_tog, "toggle");
    chk("R8", valid, exp_valid, "valid");
  endtask

  // Open a window of len cycles; last sample is last_f; earlier ones random.
  task automatic window(input int len, input int last_f, input int first_f, input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check_all("R5");
      exp_tog = 1'b0;
      awake = 1'b1;
      if (i == len - 1)  field = FW'(last_f);
      else if (i == 0)   field = FW'(first_f);
      else               field = FW'(pick_field());
    end
    begin
      int d = decide(last_f);
      logic nxt = exp_out;
      if (d == 1) nxt = 1'b0;
      if (d == 2) nxt = 1'b1;
      if (d != 0) exp_valid = 1'b1;
      exp_tog = (nxt != exp_out);
      exp_out = nxt;
    end
    @(negedge clk);
    awake = 1'b0;
    field = FW'(pick_field());
    @(negedge clk);
    check_all(req);
    exp_tog = 1'b0;
  endtask

  task automatic sleep(input int n);
    for (int i = 0; i < n; i++) begin
      field = FW'(pick_field());
      @(negedge clk);
      check_all("R5");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R8: in-band window leaves the output at its reset level, still invalid
    window(2, 100, 100, "R8");
    // R9: exact operate threshold is a crossing
    window(1, OPT, OPT, "R9");
    sleep(3);
    // R9/R4: one below operate and one above release stay inside the band
    window(1, OPT - 1, OPT - 1, "R9");
    window(1, RPT + 1, RPT + 1, "R4");
    // R9: exact release threshold is a crossing
    window(2, RPT, 0, "R3");
    // R6: early operate sample, last in band -> hold
    window(3, 0, 2000, "R6");
    // R6: early release sample, last at operate -> low
    window(3, 1500, -2000, "R6");
    // R2/R3 with full-scale values
    window(1, 2047, 2047, "R2");
    window(1, -2048, -2048, "R3");
    sleep(2);

    for (int k = 0; k < 400; k++) begin
      window(int'($urandom_range(1, 5)), pick_field(), pick_field(), "R2");
      sleep(int'($urandom_range(1, 5)));
    end

    // R1: reset mid-life restores the start state
    @(negedge clk);
    rst_n = 1'b0;
    exp_out = 1'b1; exp_valid = 1'b0; exp_tog = 1'b0;
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    sleep(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule